// File: doc/BRIEF.md
# Switch-Node Fault and Over-Temperature Monitor

This block supervises one phase of a synchronous buck power stage. At every edge of the PWM command it looks at a switch-node comparator to judge whether the power switches behaved: after the command falls, the node must have dropped below a low threshold (roughly 200 mV) within a fixed settling window. When the command rises, the node must not already sit above the short threshold before the high-side switch has been turned on. Each PWM period receives one verdict, good or faulty, and only an unbroken run of faulty periods latches a phase fault, so one noisy sample never trips the output.

A second path takes two temperature comparator flags, one for the trip point (about 160 °C) and one for the release point (about 135 °C). It keeps a hysteretic over-temperature state, with a short digital filter on each transition, and reacts well inside the required 100 µs. Either path enables a single drive-low signal meant for an open-drain fault pad, so the pad reads high in normal operation and is pulled low on a fault. The phase fault holds until reset. The thermal indication follows its hysteretic state.

Top module: `phase_fault_monitor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `fault_pull_low` is 0, and the consecutive-fault run starts at zero.
- R2: When `pwm_in` falls in cycle f and stays low, `sw_below_low` is sampled in cycle f+FALL_DELAY (default 4). A value of 0 there marks the PWM period that ends at the next rising edge as faulty.
- R3: In a cycle where `pwm_in` rises (it was 0 in the previous cycle, 1 now), a value of 1 on `sw_above_short` marks the period that this edge closes as faulty.
- R4: If `pwm_in` rises again before the falling-edge sample instant is reached, that sample is dropped and cannot make the period faulty.
- R5: The rising edge that closes the FAULT_CYCLES-th (default 15) consecutive faulty period sets the phase fault, and `fault_pull_low` goes to 1 two clock edges after that rising-edge cycle. Fewer consecutive faulty periods leave it at 0.
- R6: A period judged good resets the consecutive-fault run to zero.
- R7: Once set, the phase fault stays set, whatever `pwm_in` and the comparators do, until `rst_n` is asserted.
- R8: With the thermal state clear, THERM_FILTER (default 16) consecutive cycles with `temp_hot` = 1 set it; the output is 1 after the clock edge of the last of those cycles. A shorter burst has no effect.
- R9: With the thermal state set, THERM_FILTER consecutive cycles with `temp_cool` = 1 clear it. Cycles with neither flag hold the state (hysteresis), and a shorter cool burst has no effect.
- R10: `fault_pull_low` is 1 whenever either the phase fault or the thermal state is set. Clearing the thermal state does not clear a latched phase fault.
- R11: `sw_above_short` is ignored except in rising-edge cycles, and `sw_below_low` is ignored except at the falling-edge sample instant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | Synchronized PWM command, 1 = high-side on |
| sw_above_short | input | 1 | Switch node above the short threshold |
| sw_below_low | input | 1 | Switch node below the low (about 200 mV) threshold |
| temp_hot | input | 1 | Die temperature at or above the trip point |
| temp_cool | input | 1 | Die temperature at or below the release point |
| fault_pull_low | output | 1 | Drive-low enable for the open-drain fault pad |

## Verification
The bench attacks the count boundary with runs of exactly FAULT_CYCLES-1 and FAULT_CYCLES faulty periods, and with a single good period in the middle of a run. An off-by-one counter would trip one period early or late, and a counter that did not clear on a good period would trip on the split run. It makes very short low phases, so that a design that did not drop a pending falling-edge sample would report a phantom fault. It toggles the switch-node flags away from the sampling instants, where a design that sampled level instead of edges would trip. The thermal path gets bursts one cycle short of the filter length in both directions and long idle stretches between the two thresholds, and a latched phase fault has to survive a thermal release. Long random runs compare every cycle against a model of the requirements.

// File: rtl/pf_pkg.sv
// Package: shared types for the phase fault monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package pf_pkg;

    // Verdict for one PWM period, issued one cycle after its closing rising edge.
    typedef struct packed {
        logic done;   // a period has just been closed
        logic bad;    // that period contained a faulty sample
    } cyc_rpt_t;

    // Hysteretic thermal state.
    typedef enum logic {
        TH_COOL = 1'b0,
        TH_HOT  = 1'b1
    } th_state_e;

endpackage

// File: rtl/pf_edge_sampler.sv
// Module: pf_edge_sampler
// Detects PWM edges and samples the switch-node comparators at the instants
// that matter. At a rising edge, sw_above_short is checked directly. After a
// falling edge, sw_below_low is checked FALL_DELAY cycles later. If PWM rises
// first, that sample is dropped. Each rising edge closes one PWM period and
// reports it as good or bad on rpt, registered.
// Assumes: pwm_in is already synchronized to clk; FALL_DELAY >= 1.
module pf_edge_sampler
    import pf_pkg::*;
#(
    parameter int FALL_DELAY = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pwm_in,
    input  logic     sw_above_short,
    input  logic     sw_below_low,
    output cyc_rpt_t rpt
);

    localparam int WAIT_W = (FALL_DELAY < 2) ? 1 : $clog2(FALL_DELAY + 1);
    localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(FALL_DELAY - 1);

    logic              pwm_q;
    logic              pend;
    logic              bad_acc;
    logic [WAIT_W-1:0] wait_cnt;
    logic              rise;
    logic              fall;

    // Edge detection against the previous PWM value.
    always_comb begin
        rise = pwm_in & ~pwm_q;
        fall = ~pwm_in & pwm_q;
    end

    // Sampling window, per-period fault accumulation and registered verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q    <= 1'b0;
            pend     <= 1'b0;
            bad_acc  <= 1'b0;
            wait_cnt <= '0;
            rpt      <= '0;
        end else begin
            pwm_q    <= pwm_in;
            rpt.done <= rise;
            rpt.bad  <= rise & (bad_acc | sw_above_short);
            if (rise) begin
                pend    <= 1'b0;
                bad_acc <= 1'b0;
            end else if (fall) begin
                pend     <= 1'b1;
                wait_cnt <= WAIT_LOAD;
            end else if (pend) begin
                if (wait_cnt == '0) begin
                    bad_acc <= bad_acc | ~sw_below_low;
                    pend    <= 1'b0;
                end else begin
                    wait_cnt <= wait_cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pf_run_latch.sv
// Module: pf_run_latch
// Counts consecutive bad PWM periods and latches a phase fault when the run
// reaches FAULT_CYCLES. A good period clears the run. The latch holds until
// reset.
// Assumes: FAULT_CYCLES >= 1; rpt comes from pf_edge_sampler.
module pf_run_latch
    import pf_pkg::*;
#(
    parameter int FAULT_CYCLES = 15,
    localparam int CNT_W = (FAULT_CYCLES < 2) ? 1 : $clog2(FAULT_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cyc_rpt_t         rpt,
    output logic [CNT_W-1:0] run_cnt,
    output logic             phase_latched
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FAULT_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FAULT_CYCLES);

    // Run counter with saturation, and the sticky phase-fault latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt       <= '0;
            phase_latched <= 1'b0;
        end else if (rpt.done) begin
            if (rpt.bad) begin
                if (run_cnt >= CNT_LAST) begin
                    run_cnt       <= CNT_MAX;
                    phase_latched <= 1'b1;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/pf_thermal_hyst.sv
// Module: pf_thermal_hyst
// Keeps a hysteretic over-temperature state from two comparator flags. The
// state sets after THERM_FILTER consecutive hot cycles and clears after
// THERM_FILTER consecutive cool cycles. With THERM_FILTER <= 1 there is no
// filter.
// Assumes: temp_hot and temp_cool are synchronized to clk.
module pf_thermal_hyst
    import pf_pkg::*;
#(
    parameter int THERM_FILTER = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic temp_hot,
    input  logic temp_cool,
    output logic therm_flag
);

    th_state_e state;

    assign therm_flag = (state == TH_HOT);

    generate
        if (THERM_FILTER <= 1) begin : g_direct
            // Immediate hysteresis: set on hot, clear on cool.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    state <= TH_COOL;
                end else if (state == TH_COOL && temp_hot) begin
                    state <= TH_HOT;
                end else if (state == TH_HOT && temp_cool) begin
                    state <= TH_COOL;
                end
            end
        end else begin : g_filtered
            localparam int FW = $clog2(THERM_FILTER + 1);
            localparam logic [FW-1:0] F_LAST = FW'(THERM_FILTER - 1);

            logic [FW-1:0] dwell;
            logic          toward;

            // Selects the flag that would move the state away from where it is.
            always_comb begin
                toward = (state == TH_COOL) ? temp_hot : temp_cool;
            end

            // Counts consecutive cycles that push toward the other state.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    state <= TH_COOL;
                    dwell <= '0;
                end else if (toward) begin
                    if (dwell == F_LAST) begin
                        state <= (state == TH_COOL) ? TH_HOT : TH_COOL;
                        dwell <= '0;
                    end else begin
                        dwell <= dwell + 1'b1;
                    end
                end else begin
                    dwell <= '0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/phase_fault_monitor.sv
// Module: phase_fault_monitor (top)
// Merges the edge-timed switch-node check, the consecutive-fault latch and
// the hysteretic thermal flag into one drive-low enable for an open-drain
// fault pad (1 = pull the pad low).
// Assumes: all inputs are synchronous to clk; reset is synchronous and active-low.
module phase_fault_monitor
    import pf_pkg::*;
#(
    parameter int FAULT_CYCLES = 15,
    parameter int FALL_DELAY   = 4,
    parameter int THERM_FILTER = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic sw_above_short,
    input  logic sw_below_low,
    input  logic temp_hot,
    input  logic temp_cool,
    output logic fault_pull_low
);

    localparam int CNT_W = (FAULT_CYCLES < 2) ? 1 : $clog2(FAULT_CYCLES + 1);

    cyc_rpt_t         cyc_rpt;
    logic [CNT_W-1:0] run_cnt;
    logic             phase_latched;
    logic             therm_flag;

    pf_edge_sampler #(
        .FALL_DELAY(FALL_DELAY)
    ) u_sampler (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwm_in        (pwm_in),
        .sw_above_short(sw_above_short),
        .sw_below_low  (sw_below_low),
        .rpt           (cyc_rpt)
    );

    pf_run_latch #(
        .FAULT_CYCLES(FAULT_CYCLES)
    ) u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .rpt          (cyc_rpt),
        .run_cnt      (run_cnt),
        .phase_latched(phase_latched)
    );

    pf_thermal_hyst #(
        .THERM_FILTER(THERM_FILTER)
    ) u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_hot  (temp_hot),
        .temp_cool (temp_cool),
        .therm_flag(therm_flag)
    );

    // Either path enables the pad pull-down.
    assign fault_pull_low = phase_latched | therm_flag;

endmodule

// File: rtl/phase_fault_monitor_chk.sv
// Module: phase_fault_monitor_chk
// Assertion checker bound to phase_fault_monitor.
// Assumes: CNT_W matches the top's run counter width.
module phase_fault_monitor_chk #(
    parameter int FAULT_CYCLES = 15,
    parameter int CNT_W        = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_in,
    input logic             temp_hot,
    input logic             temp_cool,
    input logic             fault_pull_low,
    input logic             phase_latched,
    input logic             therm_flag,
    input logic             cyc_done,
    input logic             cyc_bad,
    input logic [CNT_W-1:0] run_cnt
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fault_pull_low);

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_latched |=> phase_latched);

    // R5
    latch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_latched) |-> $past(cyc_done && cyc_bad));

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CNT_W'(FAULT_CYCLES));

    // R6
    good_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !cyc_bad) |=> (run_cnt == '0));

    // R3
    verdict_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> $past(pwm_in));

    // R8
    therm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(therm_flag) |-> $past(temp_hot));

    // R9
    therm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(therm_flag) |-> $past(temp_cool));

endmodule

bind phase_fault_monitor phase_fault_monitor_chk #(
    .FAULT_CYCLES(FAULT_CYCLES),
    .CNT_W       (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwm_in        (pwm_in),
    .temp_hot      (temp_hot),
    .temp_cool     (temp_cool),
    .fault_pull_low(fault_pull_low),
    .phase_latched (phase_latched),
    .therm_flag    (therm_flag),
    .cyc_done      (cyc_rpt.done),
    .cyc_bad       (cyc_rpt.bad),
    .run_cnt       (run_cnt)
);

// File: tb/phase_fault_monitor_bench.sv
`timescale 1ns/1ps
module phase_fault_monitor_bench;

    localparam int FAULT_CYCLES = 15;
    localparam int FALL_DELAY   = 4;
    localparam int THERM_FILTER = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_in = 1'b0, sw_above_short = 1'b0, sw_below_low = 1'b1;
    logic temp_hot = 1'b0, temp_cool = 1'b0;
    logic fault_pull_low;

    int n_cmp = 0;
    int n_bad = 0;
    bit th_h = 0, th_c = 0;

    // Requirement model state
    bit m_prev, m_pend, m_acc, m_done, m_done_bad, m_latch, m_th;
    int m_wait, m_run, m_dwell;

    always #2.5 clk = ~clk;

    phase_fault_monitor #(
        .FAULT_CYCLES(FAULT_CYCLES),
        .FALL_DELAY  (FALL_DELAY),
        .THERM_FILTER(THERM_FILTER)
    ) u_phase_fault_monitor (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwm_in        (pwm_in),
        .sw_above_short(sw_above_short),
        .sw_below_low  (sw_below_low),
        .temp_hot      (temp_hot),
        .temp_cool     (temp_cool),
        .fault_pull_low(fault_pull_low)
    );

    function automatic bit exp_out();
        return m_latch | m_th;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input string tag, input bit act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prev = 0; m_pend = 0; m_acc = 0; m_done = 0; m_done_bad = 0;
        m_latch = 0; m_th = 0; m_wait = 0; m_run = 0; m_dwell = 0;
    endtask

    // Advances the requirement model by one clock edge using the driven inputs.
    task automatic model_tick();
        bit rise, fall, n_done, n_bad_v, toward;
        // R5/R6/R7: the verdict closed one edge earlier updates the run
        if (m_done) begin
            if (m_done_bad) begin
                if (m_run + 1 >= FAULT_CYCLES) m_latch = 1;
                m_run = (m_run + 1 > FAULT_CYCLES) ? FAULT_CYCLES : m_run + 1;
            end else begin
                m_run = 0;
            end
        end
        // R2/R3/R4/R11: edge-timed sampling
        rise = pwm_in && !m_prev;
        fall = !pwm_in && m_prev;
        n_done  = rise;
        n_bad_v = rise && (m_acc || sw_above_short);
        if (rise) begin
            m_pend = 0; m_acc = 0;
        end else if (fall) begin
            m_pend = 1; m_wait = FALL_DELAY - 1;
        end else if (m_pend) begin
            if (m_wait == 0) begin
                m_acc = m_acc || !sw_below_low; m_pend = 0;
            end else begin
                m_wait--;
            end
        end
        m_prev = pwm_in;
        m_done = n_done;
        m_done_bad = n_bad_v;
        // R8/R9: filtered hysteresis
        toward = m_th ? temp_cool : temp_hot;
        if (toward) begin
            if (m_dwell == THERM_FILTER - 1) begin
                m_th = !m_th; m_dwell = 0;
            end else begin
                m_dwell++;
            end
        end else begin
            m_dwell = 0;
        end
    endtask

    task automatic step(input bit p, input bit sh, input bit bl, input bit hot,
                        input bit cool, input string tag);
        pwm_in = p; sw_above_short = sh; sw_below_low = bl;
        temp_hot = hot; temp_cool = cool;
        @(posedge clk);
        if (rst_n) model_tick();
        @(negedge clk);
        check(tag, fault_pull_low, exp_out());
    endtask

    task automatic do_reset();
        rst_n = 0;
        pwm_in = 0; sw_above_short = 0; sw_below_low = 1;
        temp_hot = 0; temp_cool = 0; th_h = 0; th_c = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 output idle in reset", fault_pull_low, 1'b0);
        rst_n = 1;
        model_reset();
    endtask

    // One PWM period: rising edge with sh_rise, high phase, then a low phase
    // during which sw_below_low holds bl_low. Other comparator values are noise (R11).
    task automatic pcycle(input bit sh_rise, input bit bl_low, input int hi_len,
                          input int lo_len, input string tag);
        step(1, sh_rise, 1'($urandom % 2), th_h, th_c, tag);
        for (int i = 1; i < hi_len; i++)
            step(1, 1'($urandom % 2), 1'($urandom % 2), th_h, th_c, {tag, " R11 noise"});
        for (int i = 0; i < lo_len; i++)
            step(0, 1'($urandom % 2), bl_low, th_h, th_c, {tag, " R11 noise"});
    endtask

    task automatic idle(input int n, input bit hot, input bit cool, input string tag);
        for (int i = 0; i < n; i++) step(0, 1'($urandom % 2), 1'($urandom % 2), hot, cool, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        check("R1 first cycle after reset", fault_pull_low, 1'b0);

        // R3 and R5: shorted-node samples at rising edges
        for (int i = 0; i < FAULT_CYCLES - 1; i++) pcycle(1, 1, 3, 8, "R3 rise short");
        check("R5 below count", fault_pull_low, 1'b0);
        pcycle(1, 1, 3, 8, "R5 reach count");
        check("R5 latched at count", fault_pull_low, 1'b1);

        // R7: good periods and idle PWM do not release it
        for (int i = 0; i < 10; i++) pcycle(0, 1, 3, 8, "R7 good after latch");
        idle(20, 0, 0, "R7 idle after latch");
        check("R7 still latched", fault_pull_low, 1'b1);
        do_reset();

        // R2: node fails to fall; first rise closes an empty period
        for (int i = 0; i < FAULT_CYCLES; i++) pcycle(0, 0, 3, 8, "R2 fall stuck");
        check("R2 one short of count", fault_pull_low, 1'b0);
        pcycle(0, 0, 3, 8, "R2 fall stuck last");
        check("R2 latched", fault_pull_low, 1'b1);
        do_reset();

        // R4: low phase shorter than the sample delay drops the sample
        for (int i = 0; i < 30; i++) pcycle(0, 0, 2, FALL_DELAY, "R4 short low");
        check("R4 no fault from dropped samples", fault_pull_low, 1'b0);
        do_reset();

        // R6: one good period splits the run
        for (int i = 0; i < FAULT_CYCLES - 1; i++) pcycle(1, 1, 3, 8, "R6 first run");
        pcycle(0, 1, 3, 8, "R6 good period");
        for (int i = 0; i < FAULT_CYCLES - 1; i++) pcycle(1, 1, 3, 8, "R6 second run");
        check("R6 split run no fault", fault_pull_low, 1'b0);
        pcycle(1, 1, 3, 8, "R6 run completes");
        check("R6 full run latches", fault_pull_low, 1'b1);
        do_reset();

        // R8: thermal set filter
        idle(THERM_FILTER - 1, 1, 0, "R8 short hot burst");
        check("R8 short burst ignored", fault_pull_low, 1'b0);
        idle(1, 0, 0, "R8 gap");
        idle(THERM_FILTER - 1, 1, 0, "R8 hot");
        check("R8 one short", fault_pull_low, 1'b0);
        idle(1, 1, 0, "R8 hot last");
        check("R8 set after filter", fault_pull_low, 1'b1);

        // R9: hysteresis and release filter
        idle(40, 0, 0, "R9 between thresholds");
        check("R9 holds between thresholds", fault_pull_low, 1'b1);
        idle(THERM_FILTER - 1, 0, 1, "R9 short cool");
        idle(1, 0, 0, "R9 gap");
        check("R9 short cool ignored", fault_pull_low, 1'b1);
        idle(THERM_FILTER, 0, 1, "R9 cool");
        check("R9 released", fault_pull_low, 1'b0);
        do_reset();

        // R10: thermal release leaves a phase fault standing
        for (int i = 0; i < FAULT_CYCLES; i++) pcycle(1, 1, 3, 8, "R10 phase run");
        idle(THERM_FILTER, 1, 0, "R10 hot");
        idle(THERM_FILTER, 0, 1, "R10 cool");
        check("R10 phase fault survives thermal release", fault_pull_low, 1'b1);

        // Random rounds compared against the model every cycle
        for (int r = 0; r < 4; r++) begin
            int sh_pct;
            int tmode;
            bit p;
            do_reset();
            sh_pct = (r == 0) ? 0 : (r == 1) ? 10 : (r == 2) ? 90 : 50;
            tmode = 0; p = 0;
            for (int i = 0; i < 1500; i++) begin
                if ($urandom % 100 < 4) tmode = int'($urandom % 3);
                if ($urandom % 100 < 20) p = !p;
                step(p, 1'($urandom % 100 < sh_pct), 1'($urandom % 100 < 85),
                     tmode == 1, tmode == 2, "R5 R9 random");
            end
        end

        summary();
        $finish;
    end

endmodule